// File: doc/BRIEF.md
# Trigger Throttle State Generator

This block turns the fill level of a local trigger-request FIFO into a throttle state. It then merges that state with the throttle codes reported by twelve front-end cards and drives one four-bit code that tells the trigger source whether to keep sending, slow down or stop. The local state moves between ready, warning, busy and sync-lost on fill-level thresholds. The upward and downward thresholds differ, so a level sitting near a boundary does not make the state chatter.

The local state register moves at most one step per clock and is judged against the level presented in that cycle. The merge is combinational: the most severe of the local state and the twelve card states wins. A five-bit monitoring word carries the merged state with one flag per severity. While the run-mode flag is low, the block reports busy no matter what its inputs are, and the local state returns to ready.

Top module: `thr_state_gen`

## Requirements
- R1: While run_en is low (including right after reset) tts_code is 4'b0100 and mon_status is 5'b00010, whatever the level and card inputs are, and the local state goes back to ready at the next clock.
- R2: In the ready state, a level of 96 or more moves the local state to warning at the next clock. A level of 95 or less keeps it in ready.
- R3: In the warning state, a level of 63 or less returns the local state to ready at the next clock. Levels from 64 to 223 keep it in warning.
- R4: In the warning state, a level of 224 or more moves the local state to busy at the next clock.
- R5: In the busy state, a level of 223 or less returns the local state to warning at the next clock. A level of exactly 224 keeps it in busy.
- R6: In the busy state, a level of 225 or more moves the local state to sync-lost. Sync-lost is kept at any level until run_en drops or reset is applied.
- R7: Card codes decode as follows: 4'b0000 or 4'b1111 is disconnected, 4'b1100 is error, 4'b0010 is sync-lost, 4'b0100 is busy, 4'b0001 is warning and 4'b1000 is ready. Every other value counts as error. The merged state is the most severe of the local state and all cards, in the order disconnected > error > sync-lost > busy > warning > ready.
- R8: tts_code encodes the merged state as disconnected 4'b0000, error 4'b1100, sync-lost 4'b0010, busy 4'b0100, warning 4'b0001 and ready 4'b1000.
- R9: mon_status sets exactly one bit for the merged state: bit4 disconnected, bit3 error, bit2 sync-lost, bit1 busy, bit0 warning. It is all zero for ready.
- R10: The local state moves at most one step per clock. From ready, a level of 230 reaches busy after two clocks and sync-lost after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run-mode flag; low forces busy |
| fifo_level | input | LVL_W (10) | Current trigger-request FIFO occupancy |
| card_codes | input | 4*N_CARD (48) | Card throttle codes, card k in bits [4k+3:4k] |
| tts_code | output | 4 | Merged throttle code |
| mon_status | output | 5 | Merged state in one-flag monitoring format |

## Verification
Sync-lost is the hardest state to reach from the ports. It can only be entered by walking the level through warning and busy, one step per clock, and it then hides behind any more severe card code. The stimulus climbs the level in stages: it holds 224 to prove busy holds, steps to 225, then drops to zero to show the state sticks. It then pulses run_en to clear it. A long random phase biases levels around every threshold and mixes legal, illegal and ready card codes. A behavioural model is compared against the outputs on every cycle.

// File: rtl/thr_state_gen.sv
module thr_state_gen #(
  parameter int N_CARD   = 12,
  parameter int LVL_W    = 10,
  parameter int WARN_ON  = 96,
  parameter int WARN_OFF = 63,
  parameter int BUSY_ON  = 224,
  parameter int BUSY_OFF = 223,
  parameter int SYNC_ON  = 225
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_en,
  input  logic [LVL_W-1:0]      fifo_level,
  input  logic [4*N_CARD-1:0]   card_codes,
  output logic [3:0]            tts_code,
  output logic [4:0]            mon_status
);

  localparam logic [LVL_W-1:0] WARN_ON_L  = LVL_W'(WARN_ON);
  localparam logic [LVL_W-1:0] WARN_OFF_L = LVL_W'(WARN_OFF);
  localparam logic [LVL_W-1:0] BUSY_ON_L  = LVL_W'(BUSY_ON);
  localparam logic [LVL_W-1:0] BUSY_OFF_L = LVL_W'(BUSY_OFF);
  localparam logic [LVL_W-1:0] SYNC_ON_L  = LVL_W'(SYNC_ON);

  typedef enum logic [1:0] {L_RDY, L_WARN, L_BUSY, L_SYNC} lstate_t;

  lstate_t lstate, lstate_nx;

  always_comb begin
    lstate_nx = lstate;
    unique case (lstate)
      L_RDY:  if (fifo_level >= WARN_ON_L) lstate_nx = L_WARN;
      L_WARN: if (fifo_level >= BUSY_ON_L) lstate_nx = L_BUSY;
              else if (fifo_level <= WARN_OFF_L) lstate_nx = L_RDY;
      L_BUSY: if (fifo_level >= SYNC_ON_L) lstate_nx = L_SYNC;
              else if (fifo_level <= BUSY_OFF_L) lstate_nx = L_WARN;
      L_SYNC: lstate_nx = L_SYNC;
      default: lstate_nx = L_RDY;
    endcase
    if (!run_en) lstate_nx = L_RDY;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lstate <= L_RDY;
    else        lstate <= lstate_nx;

  logic [4:0] local_flag;
  always_comb
    unique case (lstate)
      L_WARN:  local_flag = 5'b00001;
      L_BUSY:  local_flag = 5'b00010;
      L_SYNC:  local_flag = 5'b00100;
      default: local_flag = 5'b00000;
    endcase

  logic [4:0] card_flag [N_CARD];

  for (genvar g = 0; g < N_CARD; g++) begin : g_card
    always_comb
      case (card_codes[4*g +: 4])
        4'b0000, 4'b1111: card_flag[g] = 5'b10000;
        4'b1100:          card_flag[g] = 5'b01000;
        4'b0010:          card_flag[g] = 5'b00100;
        4'b0100:          card_flag[g] = 5'b00010;
        4'b0001:          card_flag[g] = 5'b00001;
        4'b1000:          card_flag[g] = 5'b00000;
        default:          card_flag[g] = 5'b01000;
      endcase
  end

  logic [4:0] any_flag;
  always_comb begin
    any_flag = local_flag;
    for (int k = 0; k < N_CARD; k++) any_flag = any_flag | card_flag[k];
  end

  wire [4:0] merged = run_en ? any_flag : 5'b00010;

  always_comb begin
    mon_status = 5'b00000;
    if      (merged[4]) mon_status = 5'b10000;
    else if (merged[3]) mon_status = 5'b01000;
    else if (merged[2]) mon_status = 5'b00100;
    else if (merged[1]) mon_status = 5'b00010;
    else if (merged[0]) mon_status = 5'b00001;
  end

  always_comb
    unique case (mon_status)
      5'b10000: tts_code = 4'b0000;
      5'b01000: tts_code = 4'b1100;
      5'b00100: tts_code = 4'b0010;
      5'b00010: tts_code = 4'b0100;
      5'b00001: tts_code = 4'b0001;
      default:  tts_code = 4'b1000;
    endcase

  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> lstate == L_RDY);
  assert_idle_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> tts_code == 4'b0100);
  assert_warn_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lstate == L_RDY && run_en && fifo_level >= WARN_ON_L) |=> lstate == L_WARN);
  assert_warn_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lstate == L_WARN && run_en && fifo_level <= WARN_OFF_L) |=> lstate == L_RDY);
  assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lstate == L_WARN && run_en && fifo_level >= BUSY_ON_L) |=> lstate == L_BUSY);
  assert_busy_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lstate == L_BUSY && run_en && fifo_level <= BUSY_OFF_L) |=> lstate == L_WARN);
  assert_sync_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lstate == L_SYNC && run_en) |=> lstate == L_SYNC);
  assert_ready_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_status == 5'b00000) |-> tts_code == 4'b1000);
  assert_mon_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mon_status));
  assert_one_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lstate == L_RDY) |=> (lstate != L_BUSY && lstate != L_SYNC));

endmodule

// File: tb/thr_state_gen_tb.sv
module thr_state_gen_tb_top;
  localparam int NC = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic run_en = 0;
  logic [9:0] fifo_level = '0;
  logic [4*NC-1:0] card_codes;
  logic [3:0] tts_code;
  logic [4:0] mon_status;

  int checks = 0, failures = 0;
  int mst = 0; // 0 ready 1 warn 2 busy 3 sync

  always #5 clk = ~clk;

  thr_state_gen dut_i (.clk(clk), .rst_n(rst_n), .run_en(run_en),
    .fifo_level(fifo_level), .card_codes(card_codes),
    .tts_code(tts_code), .mon_status(mon_status));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mst <= 0;
    else if (!run_en) mst <= 0;
    else begin
      case (mst)
        0: if (fifo_level >= 96) mst <= 1;
        1: if (fifo_level >= 224) mst <= 2; else if (fifo_level <= 63) mst <= 0;
        2: if (fifo_level >= 225) mst <= 3; else if (fifo_level <= 223) mst <= 1;
        default: mst <= 3;
      endcase
    end
  end

  function automatic int card_sev(logic [3:0] c);
    case (c)
      4'b0000, 4'b1111: return 5;
      4'b1100: return 4;
      4'b0010: return 3;
      4'b0100: return 2;
      4'b0001: return 1;
      4'b1000: return 0;
      default: return 4;
    endcase
  endfunction

  task automatic check(string tag);
    int sev;
    logic [3:0] ec;
    logic [4:0] em;
    if (!run_en || !rst_n) sev = 2;
    else begin
      sev = mst;
      for (int k = 0; k < NC; k++)
        if (card_sev(card_codes[4*k +: 4]) > sev) sev = card_sev(card_codes[4*k +: 4]);
    end
    em = (sev == 0) ? 5'b0 : 5'(1 << (sev - 1));
    case (sev)
      5: ec = 4'b0000; 4: ec = 4'b1100; 3: ec = 4'b0010;
      2: ec = 4'b0100; 1: ec = 4'b0001; default: ec = 4'b1000;
    endcase
    checks++;
    if (tts_code !== ec || mon_status !== em) begin
      failures++;
      $display("FAIL %s: tts=%b mon=%b expected tts=%b mon=%b (level=%0d)",
               tag, tts_code, mon_status, ec, em, fifo_level);
    end
  endtask

  task automatic step(int lvl, logic run, string tag);
    @(negedge clk);
    fifo_level = 10'(lvl);
    run_en = run;
    #1 check(tag);
  endtask

  task automatic all_cards(logic [3:0] c);
    for (int k = 0; k < NC; k++) card_codes[4*k +: 4] = c;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    all_cards(4'b1000);
    #2 check("R1");
    fifo_level = 10'd300;
    #1 check("R1");
    repeat (3) @(posedge clk);
    rst_n = 1;
    step(300, 0, "R1");
    all_cards(4'b0000);
    step(0, 0, "R1");
    all_cards(4'b1000);
    step(0, 1, "R2");
    step(95, 1, "R2");
    step(95, 1, "R2");
    step(96, 1, "R2");
    step(96, 1, "R2");
    step(64, 1, "R3");
    step(64, 1, "R3");
    step(63, 1, "R3");
    step(63, 1, "R3");
    step(100, 1, "R2");
    step(223, 1, "R3");
    step(224, 1, "R4");
    step(224, 1, "R4");
    step(224, 1, "R5");
    step(223, 1, "R5");
    step(223, 1, "R5");
    step(224, 1, "R4");
    step(225, 1, "R6");
    step(225, 1, "R6");
    step(0, 1, "R6");
    step(0, 1, "R6");
    step(0, 1, "R6");
    step(0, 0, "R1");
    step(0, 1, "R6");
    step(0, 1, "R6");
    step(230, 1, "R10");
    step(230, 1, "R10");
    step(230, 1, "R10");
    step(230, 1, "R10");
    step(0, 0, "R10");
    step(0, 1, "R10");
    // card merge cases with local ready
    card_codes[4*5 +: 4] = 4'b0001; step(0, 1, "R7");
    card_codes[4*0 +: 4] = 4'b0100; step(0, 1, "R7");
    card_codes[4*11 +: 4] = 4'b0010; step(0, 1, "R8");
    card_codes[4*3 +: 4] = 4'b0011; step(0, 1, "R7");
    card_codes[4*3 +: 4] = 4'b1100; step(0, 1, "R9");
    card_codes[4*7 +: 4] = 4'b1111; step(0, 1, "R7");
    card_codes[4*7 +: 4] = 4'b0000; step(0, 1, "R8");
    step(0, 0, "R1");
    all_cards(4'b1000);
    card_codes[4*2 +: 4] = 4'b0001;
    step(120, 1, "R7");
    step(120, 1, "R7");
    card_codes[4*2 +: 4] = 4'b1000;
    step(120, 1, "R9");
    // random phase around thresholds
    for (int i = 0; i < 4000; i++) begin
      int pick, lvl;
      logic run;
      pick = int'($urandom_range(0, 9));
      case (pick)
        0: lvl = int'($urandom_range(0, 1023));
        1: lvl = 96 + int'($urandom_range(0, 2)) - 1;
        2: lvl = 63 + int'($urandom_range(0, 2)) - 1;
        3, 4: lvl = 222 + int'($urandom_range(0, 4));
        5: lvl = int'($urandom_range(60, 100));
        default: lvl = int'($urandom_range(90, 240));
      endcase
      run = ($urandom_range(0, 99) != 0);
      all_cards(4'b1000);
      if ($urandom_range(0, 3) == 0) begin
        int k;
        k = int'($urandom_range(0, NC - 1));
        card_codes[4*k +: 4] = 4'($urandom_range(0, 15));
      end
      step(lvl, run, (i % 2 == 0) ? "R7" : "R10");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule